// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block owns the program counter of a single-issue core that fetches the next sequential instruction in every cycle while the current one executes. It presents a word fetch address to instruction memory and takes back the word read there in the same cycle. That word is captured into a decode register, together with its address. Control transfers are delayed by one instruction. When a taken branch sits in decode, the fetch already in flight is the instruction after it, and that instruction is allowed to complete. The branch target becomes the fetch address in the following cycle. No prediction and no flushing are needed.

Decode supplies the branch kind, a 4-bit condition code, a 19-bit signed displacement for PC-relative transfers, and a full register value for indirect transfers such as returns. The block keeps the condition flags in its own register. That register is written only when the executing instruction asks for it. A two-cycle memory instruction raises a stall request, and the stall freezes the whole sequencer for that cycle. Calls are PC-relative transfers with the always condition. Returns are register transfers.

Top module: `dbr_pc_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` equals RESET_PC (default 0), and `fetch_req` and `dec_valid` are 0. `dec_valid` is never 1 while `fetch_req` is 0.
- R2: At the first rising edge with `rst_n` high, `fetch_req` becomes 1 while `fetch_addr` stays at RESET_PC and `dec_valid` stays 0. The first instruction is captured at the edge after that.
- R3: In every cycle with `fetch_req` high and `mem_stall` low, the next edge loads `dec_instr` with `imem_rdata`, loads `dec_pc` with `fetch_addr`, and sets `dec_valid`. When no branch is taken, `fetch_addr` increments by one word.
- R4: A taken branch in decode does not cancel the instruction being fetched. The word at branch address + 1 always reaches decode next, and the target reaches decode in the cycle after that. For example, a branch at 102 targeting 105 gives the decode order 100, 101, 102, 103, 105.
- R5: `br_kind` = 2'b01 is PC-relative. Its target is `dec_pc` plus `br_disp` sign-extended from 19 bits to the address width.
- R6: `br_kind` = 2'b10 is register-indirect, and its target is `br_reg_tgt`. `br_kind` = 2'b00 and 2'b11 never redirect.
- R7: A branch is taken only when `dec_valid` is 1 and the condition holds on the stored flags {N,Z,V,C} (bits 3..0). The codes are: 0 never, 1 signed greater (!(Z|(N^V))), 2 signed less-or-equal, 3 signed greater-or-equal (!(N^V)), 4 signed less (N^V), 5 unsigned higher (!(C|Z)), 6 unsigned lower-or-same (C|Z), 7 carry set, 8 carry clear, 9 plus (!N), 10 minus (N), 11 not equal (!Z), 12 equal (Z), 13 no overflow (!V), 14 overflow (V), 15 always.
- R8: The stored flags take `cc_in` at a rising edge only when `cc_we` is 1, and they are 0 after reset. A branch tests the flags as they stand before the edge at which it is resolved.
- R9: In a cycle with `mem_stall` high, `fetch_addr`, `dec_pc`, `dec_instr` and `dec_valid` hold their values, and any branch request in that cycle is ignored.
- R10: If a taken branch occupies the delay slot of another taken branch, the first target executes once, as the slot of the second branch, and fetch then continues at the second target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Fetch address is valid |
| fetch_addr | output | AW | Word address of the instruction being fetched |
| imem_rdata | input | IW | Instruction word at `fetch_addr`, same cycle |
| dec_valid | output | 1 | Decode register holds a fetched instruction |
| dec_pc | output | AW | Address of the instruction in decode |
| dec_instr | output | IW | Instruction word in decode |
| br_kind | input | 2 | 00 none, 01 PC-relative, 10 register, 11 none |
| br_cond | input | 4 | Condition code of the branch in decode |
| br_disp | input | DISP_W | Signed word displacement |
| br_reg_tgt | input | AW | Register-supplied target address |
| cc_we | input | 1 | Executing instruction updates flags |
| cc_in | input | 4 | New flags {N,Z,V,C} |
| mem_stall | input | 1 | Hold the sequencer for this cycle |

## Verification
The bench builds the block with a 32-bit address, a 32-bit instruction word and a 19-bit displacement. With these values, the 13 upper address bits produced by sign extension are checked for both forward and backward displacements. The memory model derives each instruction word from its address, so any fetch address the sequencer reaches can be checked without a stored program. The 19-bit displacement also lets random transfers land far from the current address, so adds that cross wide bit boundaries are covered.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   typedef enum logic [1:0] {
      BK_NONE = 2'b00,
      BK_REL  = 2'b01,
      BK_REG  = 2'b10,
      BK_RSVD = 2'b11
   } br_kind_e;

   typedef enum logic [3:0] {
      CND_NEVER  = 4'd0,
      CND_SGT    = 4'd1,
      CND_SLE    = 4'd2,
      CND_SGE    = 4'd3,
      CND_SLT    = 4'd4,
      CND_UHI    = 4'd5,
      CND_ULS    = 4'd6,
      CND_CSET   = 4'd7,
      CND_CCLR   = 4'd8,
      CND_PLUS   = 4'd9,
      CND_MINUS  = 4'd10,
      CND_NZERO  = 4'd11,
      CND_ZERO   = 4'd12,
      CND_NOVF   = 4'd13,
      CND_OVF    = 4'd14,
      CND_ALWAYS = 4'd15
   } cond_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/dbr_cond_eval.sv
module dbr_cond_eval
   import dbr_pkg::*;
(
   input  logic [3:0] code,
   input  flags_t     flags,
   output logic       hit
);

   logic sgn_lt;
   assign sgn_lt = flags.n ^ flags.v;

   // R7: condition decode on the stored flags
   always_comb begin
      hit = 1'b0;
      case (cond_e'(code))
         CND_NEVER:  hit = 1'b0;
         CND_SGT:    hit = ~(flags.z | sgn_lt);
         CND_SLE:    hit = flags.z | sgn_lt;
         CND_SGE:    hit = ~sgn_lt;
         CND_SLT:    hit = sgn_lt;
         CND_UHI:    hit = ~(flags.c | flags.z);
         CND_ULS:    hit = flags.c | flags.z;
         CND_CSET:   hit = flags.c;
         CND_CCLR:   hit = ~flags.c;
         CND_PLUS:   hit = ~flags.n;
         CND_MINUS:  hit = flags.n;
         CND_NZERO:  hit = ~flags.z;
         CND_ZERO:   hit = flags.z;
         CND_NOVF:   hit = ~flags.v;
         CND_OVF:    hit = flags.v;
         CND_ALWAYS: hit = 1'b1;
      endcase
   end

endmodule

// File: rtl/dbr_target_gen.sv
module dbr_target_gen
   import dbr_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DISP_W = 19
) (
   input  br_kind_e          kind,
   input  logic [AW-1:0]     base_pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [AW-1:0]     reg_tgt,
   output logic              is_xfer,
   output logic [AW-1:0]     target
);

   localparam int EXT_W = AW - DISP_W;

   logic [AW-1:0] disp_ext;

   generate
      if (EXT_W == 0) begin : g_disp_full
         assign disp_ext = disp;
      end else begin : g_disp_sext
         // R5: sign extension of the displacement
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end
   endgenerate

   always_comb begin
      is_xfer = 1'b0;
      target  = base_pc + disp_ext;
      case (kind)
         BK_REL: begin
            is_xfer = 1'b1;
            target  = base_pc + disp_ext;
         end
         BK_REG: begin
            is_xfer = 1'b1;
            target  = reg_tgt;
         end
         default: is_xfer = 1'b0;
      endcase
   end

endmodule

// File: rtl/dbr_flag_reg.sv
module dbr_flag_reg
   import dbr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   we,
   input  flags_t d,
   output flags_t q
);

   // R8: flags are written only on request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= d;
      end
   end

endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq
   import dbr_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            IW       = 32,
   parameter int            DISP_W   = 19,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              fetch_req,
   output logic [AW-1:0]     fetch_addr,
   input  logic [IW-1:0]     imem_rdata,
   output logic              dec_valid,
   output logic [AW-1:0]     dec_pc,
   output logic [IW-1:0]     dec_instr,
   input  logic [1:0]        br_kind,
   input  logic [3:0]        br_cond,
   input  logic [DISP_W-1:0] br_disp,
   input  logic [AW-1:0]     br_reg_tgt,
   input  logic              cc_we,
   input  logic [3:0]        cc_in,
   input  logic              mem_stall
);

   localparam logic [AW-1:0] PC_STEP = AW'(1);

   generate
      if (DISP_W > AW) begin : g_bad_disp
         $error("dbr_pc_seq: DISP_W must not exceed AW");
      end
      if (AW < 2) begin : g_bad_aw
         $error("dbr_pc_seq: AW must be at least 2");
      end
      if (IW < 1) begin : g_bad_iw
         $error("dbr_pc_seq: IW must be at least 1");
      end
   endgenerate

   logic          started_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] dpc_q;
   logic [IW-1:0] dinstr_q;
   logic          dval_q;
   flags_t        cc_q;
   flags_t        cc_d;

   br_kind_e      kind;
   logic          cond_hit;
   logic          is_xfer;
   logic [AW-1:0] tgt;
   logic          advance;
   logic          redirect;
   logic [AW-1:0] pc_next;

   assign kind = br_kind_e'(br_kind);
   assign cc_d = flags_t'(cc_in);

   dbr_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cc_we),
      .d     (cc_d),
      .q     (cc_q)
   );

   dbr_cond_eval u_cond (
      .code  (br_cond),
      .flags (cc_q),
      .hit   (cond_hit)
   );

   dbr_target_gen #(
      .AW     (AW),
      .DISP_W (DISP_W)
   ) u_tgt (
      .kind    (kind),
      .base_pc (dpc_q),
      .disp    (br_disp),
      .reg_tgt (br_reg_tgt),
      .is_xfer (is_xfer),
      .target  (tgt)
   );

   // R9: stall freezes everything; R4/R10: redirect only affects the next fetch
   assign advance  = started_q & ~mem_stall;
   assign redirect = dval_q & is_xfer & cond_hit;
   assign pc_next  = redirect ? tgt : (pc_q + PC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
      end else begin
         started_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         dpc_q    <= '0;
         dinstr_q <= '0;
         dval_q   <= 1'b0;
      end else if (advance) begin
         pc_q     <= pc_next;
         dpc_q    <= pc_q;
         dinstr_q <= imem_rdata;
         dval_q   <= 1'b1;
      end
   end

   assign fetch_req  = started_q;
   assign fetch_addr = pc_q;
   assign dec_valid  = dval_q;
   assign dec_pc     = dpc_q;
   assign dec_instr  = dinstr_q;

endmodule

// File: rtl/dbr_pc_seq_chk.sv
module dbr_pc_seq_chk #(
   parameter int            AW       = 32,
   parameter int            IW       = 32,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_req,
   input logic [AW-1:0] fetch_addr,
   input logic          dec_valid,
   input logic [AW-1:0] dec_pc,
   input logic [IW-1:0] dec_instr,
   input logic [1:0]    br_kind,
   input logic [3:0]    br_cond,
   input logic [AW-1:0] br_reg_tgt,
   input logic          mem_stall
);

   a_r1_decode_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> fetch_req);

   a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> (fetch_addr == RESET_PC) && !dec_valid);

   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !mem_stall) |=> dec_valid && (dec_pc == $past(fetch_addr)));

   a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !mem_stall && br_kind == 2'b00) |=> (fetch_addr == $past(fetch_addr) + AW'(1)));

   a_r6_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !mem_stall && dec_valid && br_kind == 2'b10 && br_cond == 4'd15)
      |=> (fetch_addr == $past(br_reg_tgt)));

   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && mem_stall) |=> $stable(fetch_addr) && $stable(dec_pc) && $stable(dec_instr)
                                   && $stable(dec_valid));

endmodule

bind dbr_pc_seq dbr_pc_seq_chk #(
   .AW       (AW),
   .IW       (IW),
   .RESET_PC (RESET_PC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fetch_req  (fetch_req),
   .fetch_addr (fetch_addr),
   .dec_valid  (dec_valid),
   .dec_pc     (dec_pc),
   .dec_instr  (dec_instr),
   .br_kind    (br_kind),
   .br_cond    (br_cond),
   .br_reg_tgt (br_reg_tgt),
   .mem_stall  (mem_stall)
);

// File: tb/dbr_pc_seq_tb_top.sv
module dbr_pc_seq_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 32;
   localparam int IW = 32;
   localparam int DW = 19;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;
   logic [IW-1:0] imem_rdata;
   logic          dec_valid;
   logic [AW-1:0] dec_pc;
   logic [IW-1:0] dec_instr;
   logic [1:0]    br_kind;
   logic [3:0]    br_cond;
   logic [DW-1:0] br_disp;
   logic [AW-1:0] br_reg_tgt;
   logic          cc_we;
   logic [3:0]    cc_in;
   logic          mem_stall;

   always #2.5 clk = ~clk;

   function automatic logic [IW-1:0] word_of(logic [AW-1:0] a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A_0000;
   endfunction

   always_comb imem_rdata = word_of(fetch_addr);

   dbr_pc_seq #(.AW(AW), .IW(IW), .DISP_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .imem_rdata(imem_rdata), .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_instr(dec_instr),
      .br_kind(br_kind), .br_cond(br_cond), .br_disp(br_disp), .br_reg_tgt(br_reg_tgt),
      .cc_we(cc_we), .cc_in(cc_in), .mem_stall(mem_stall)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic          m_started;
   logic [AW-1:0] m_pc;
   logic [AW-1:0] m_dpc;
   logic [IW-1:0] m_dinstr;
   logic          m_dval;
   logic [3:0]    m_cc;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // flags {N,Z,V,C}
   function automatic bit cond_true(logic [3:0] code, logic [3:0] f);
      bit n = f[3], z = f[2], v = f[1], c = f[0];
      bit lt = (n != v);
      if (code == 4'd0)  return 0;
      if (code == 4'd1)  return !z && !lt;
      if (code == 4'd2)  return z || lt;
      if (code == 4'd3)  return !lt;
      if (code == 4'd4)  return lt;
      if (code == 4'd5)  return !c && !z;
      if (code == 4'd6)  return c || z;
      if (code == 4'd7)  return c;
      if (code == 4'd8)  return !c;
      if (code == 4'd9)  return !n;
      if (code == 4'd10) return n;
      if (code == 4'd11) return !z;
      if (code == 4'd12) return z;
      if (code == 4'd13) return !v;
      if (code == 4'd14) return v;
      return 1;
   endfunction

   function automatic logic [AW-1:0] sext(logic [DW-1:0] d);
      return {{(AW-DW){d[DW-1]}}, d};
   endfunction

   task automatic compare(string tag);
      chk(fetch_req == m_started, tag, "fetch_req", 64'(fetch_req), 64'(m_started));
      chk(fetch_addr == m_pc, tag, "fetch_addr", 64'(fetch_addr), 64'(m_pc));
      chk(dec_valid == m_dval, tag, "dec_valid", 64'(dec_valid), 64'(m_dval));
      if (m_dval) begin
         chk(dec_pc == m_dpc, tag, "dec_pc", 64'(dec_pc), 64'(m_dpc));
         chk(dec_instr == m_dinstr, tag, "dec_instr", 64'(dec_instr), 64'(m_dinstr));
      end
   endtask

   // drive at negedge, update model, check at next negedge
   task automatic step(logic [1:0] k, logic [3:0] c, logic [DW-1:0] d, logic [AW-1:0] r,
                       bit st, bit we, logic [3:0] ci, string tag);
      bit taken;
      logic [AW-1:0] tgt;
      br_kind = k; br_cond = c; br_disp = d; br_reg_tgt = r;
      mem_stall = st; cc_we = we; cc_in = ci;
      if (!m_started) begin
         m_started = 1;
      end else if (!st) begin
         taken = m_dval && (k == 2'b01 || k == 2'b10) && cond_true(c, m_cc);
         tgt = (k == 2'b01) ? m_dpc + sext(d) : r;
         m_dinstr = word_of(m_pc);
         m_dpc = m_pc;
         m_dval = 1;
         m_pc = taken ? tgt : m_pc + 1;
      end
      if (we) m_cc = ci;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(string tag);
      step(2'b00, 4'd0, '0, '0, 0, 0, 4'd0, tag);
   endtask

   initial begin
      rst_n = 0;
      br_kind = 0; br_cond = 0; br_disp = 0; br_reg_tgt = 0;
      cc_we = 0; cc_in = 0; mem_stall = 0;
      m_started = 0; m_pc = 0; m_dpc = 0; m_dinstr = 0; m_dval = 0; m_cc = 0;
      void'($urandom(32'd1981));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(fetch_addr == 0, "R1", "fetch_addr in reset", 64'(fetch_addr), 0);
      chk(fetch_req == 0, "R1", "fetch_req in reset", 64'(fetch_req), 0);
      chk(dec_valid == 0, "R1", "dec_valid in reset", 64'(dec_valid), 0);
      rst_n = 1;
      // R2 first fetch one edge after release
      idle("R2");
      chk(fetch_req && fetch_addr == 0 && !dec_valid, "R2", "first fetch state",
          64'({fetch_req, dec_valid}), 64'(2'b10));
      while (!(m_dval && m_dpc == 102)) idle("R3");
      // R5/R4: branch at 102, displacement +3 -> 105
      step(2'b01, 4'd15, 19'd3, '0, 0, 0, 4'd0, "R5");
      chk(dec_pc == 103, "R4", "delay slot decoded", 64'(dec_pc), 103);
      idle("R4");
      chk(dec_pc == 105, "R4", "target after slot", 64'(dec_pc), 105);
      // R10: branch at 105 to 115, branch in its slot (106) to 56
      step(2'b01, 4'd15, 19'd10, '0, 0, 0, 4'd0, "R10");
      step(2'b01, 4'd15, -19'sd50, '0, 0, 0, 4'd0, "R10");
      chk(dec_pc == 115, "R10", "first target as slot", 64'(dec_pc), 115);
      idle("R10");
      chk(dec_pc == 56, "R10", "second target", 64'(dec_pc), 56);
      // R6: register target, and reserved kind ignored
      step(2'b10, 4'd15, '0, 32'h0000_0200, 0, 0, 4'd0, "R6");
      idle("R6");
      chk(dec_pc == 32'h200, "R6", "register target", 64'(dec_pc), 64'h200);
      step(2'b11, 4'd15, 19'd40, 32'h0000_0900, 0, 0, 4'd0, "R6");
      step(2'b00, 4'd15, 19'd40, 32'h0000_0900, 0, 0, 4'd0, "R6");
      // R8: flags held when cc_we low
      step(2'b00, 4'd0, '0, '0, 0, 1, 4'b0100, "R8");
      repeat (3) step(2'b00, 4'd0, '0, '0, 0, 0, 4'b0000, "R8");
      step(2'b01, 4'd12, 19'd20, '0, 0, 0, 4'd0, "R8");
      step(2'b01, 4'd11, 19'd20, '0, 0, 1, 4'b0000, "R8");
      step(2'b01, 4'd11, 19'd30, '0, 0, 0, 4'd0, "R8");
      idle("R8");
      // R7: every code under several flag patterns
      for (int cd = 0; cd < 16; cd++) begin
         for (int fp = 0; fp < 16; fp += 3) begin
            step(2'b00, 4'd0, '0, '0, 0, 1, 4'(fp), "R7");
            step(2'b01, 4'(cd), 19'd9, '0, 0, 0, 4'd0, "R7");
            idle("R7");
         end
      end
      // R9: stalls with branch requests pending
      step(2'b01, 4'd15, 19'd77, '0, 1, 0, 4'd0, "R9");
      step(2'b10, 4'd15, '0, 32'h1234, 1, 0, 4'd0, "R9");
      idle("R9");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] k;
         logic [DW-1:0] d;
         k = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
         d = ($urandom_range(0, 1) == 0) ? DW'($urandom_range(0, 255)) - DW'(128) : DW'($urandom());
         step(k, 4'($urandom()), d, $urandom(), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 2) == 0), 4'($urandom()), "R3");
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R3 actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule